// File: doc/BRIEF.md
# Bus Error Capture Register Unit

This unit watches a local system bus for failed transfers and keeps a record of the first one. A failed transfer is signalled by a one-cycle error strobe. The strobe comes with the faulting address, a 64-bit data value, and a set of transfer attributes. On that strobe the unit stores all of these values and then locks. While it is locked, every later error is dropped and the stored record stays unchanged.

Software reads the record through a small register port. The record is split into four 32-bit words: the address, the low data word, the high data word and an attribute word. Software releases the lock by writing a 1 to bit 0 of the attribute word. The next error is then recorded.

The attribute word packs the opcode, the transfer tag, the read, write and supervisor flags, the user-interface status, the acknowledge code, the bus-lock state and the secondary-bus master tag. These fields sit at fixed bit positions so that software can decode them.

Top module: `buserr_capture`

## Requirements
- R1: After a synchronous reset the lock flag (attribute bit 0) is 0, attribute bits [3:0] read as 0, and `reg_rdata` is 0.
- R2: An `err_strobe` while unlocked loads the address, both data words and all attribute fields from the inputs on that edge, and sets the lock flag to 1.
- R3: While the lock flag is 1 and no unlock write occurs, an `err_strobe` changes none of the stored address, data or attribute values, and the lock flag stays 1.
- R4: A write to register index 3 with `reg_wdata[0]`=1 clears the lock flag, and the next error strobe is captured.
- R5: A write to index 3 with `reg_wdata[0]`=0 leaves the lock flag unchanged. Attribute bits [31:1] cannot be changed by software. Writes to indices 0, 1 and 2 change nothing.
- R6: When an unlock write and an `err_strobe` fall in the same cycle, the new error is captured and the lock flag ends at 1.
- R7: The upper half of the attribute word holds the following fields: opcode in [31:28], transfer tag in [25:22], read flag in [21], write flag in [20], supervisor flag in [19], user-interface status in [18], and acknowledge code in [17:16].
- R8: Attribute bit 15 holds the bus-lock state: 0 means an atomic transfer and 1 means a single or block transfer. Bits [7:4] hold the 4-bit secondary-bus master tag.
- R9: Reserved attribute bits [27:26], [14:8] and [3:1] read as 0. When `ADDR_W` is below 32, the captured address reads back zero-extended.
- R10: Register index 0 reads the address, 1 the data bits [31:0], 2 the data bits [63:32], and 3 the attribute word. `reg_rdata` updates on the edge after `reg_rd_en`=1 and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_strobe | input | 1 | One-cycle failed-transfer strobe |
| err_addr | input | ADDR_W | Address of the failing transfer |
| err_data | input | DATA_W | Data of the failing transfer |
| err_opcode | input | 4 | Transfer opcode |
| err_tag | input | 4 | Transfer tag |
| err_read | input | 1 | Read transfer flag |
| err_write | input | 1 | Write transfer flag |
| err_super | input | 1 | Supervisor-mode flag |
| err_uis | input | 1 | User-interface status |
| err_ack | input | 2 | Acknowledge code |
| err_single | input | 1 | Bus-lock state: 1 means single/block, 0 means atomic |
| err_mtag | input | 4 | Secondary-bus master tag |
| reg_wr_en | input | 1 | Register write enable |
| reg_rd_en | input | 1 | Register read enable |
| reg_sel | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench builds the unit with `ADDR_W`=24 and `DATA_W`=64. The narrow address reaches the zero-extension branch of the readback, so the top eight address bits must read as 0. The full-width data keeps both data words fully exercised. With distinct patterns in every field, the bench can find a misplaced attribute field, a missed capture, or a capture that leaked through while the unit was locked.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
  localparam int REG_W  = 32;
  localparam int OPC_W  = 4;
  localparam int TAG_W  = 4;
  localparam int ACK_W  = 2;
  localparam int MTAG_W = 4;

  // attribute word field positions (software decodes these)
  localparam int LOCK_BIT  = 0;
  localparam int MTAG_LSB  = 4;
  localparam int BLOCK_BIT = 15;
  localparam int ACK_LSB   = 16;
  localparam int UIS_BIT   = 18;
  localparam int SUP_BIT   = 19;
  localparam int WR_BIT    = 20;
  localparam int RD_BIT    = 21;
  localparam int TAG_LSB   = 22;
  localparam int OPC_LSB   = 28;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DLO  = 2'd1,
    SEL_DHI  = 2'd2,
    SEL_ATTR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [TAG_W-1:0]  tag;
    logic              rd;
    logic              wr;
    logic              sup;
    logic              uis;
    logic [ACK_W-1:0]  ack;
    logic              single;
    logic [MTAG_W-1:0] mtag;
  } err_attr_t;

  function automatic logic [REG_W-1:0] pack_attr(input err_attr_t a, input logic lock);
    logic [REG_W-1:0] w;
    w = '0;
    w[OPC_LSB +: OPC_W]   = a.opc;
    w[TAG_LSB +: TAG_W]   = a.tag;
    w[RD_BIT]             = a.rd;
    w[WR_BIT]             = a.wr;
    w[SUP_BIT]            = a.sup;
    w[UIS_BIT]            = a.uis;
    w[ACK_LSB +: ACK_W]   = a.ack;
    w[BLOCK_BIT]          = a.single;
    w[MTAG_LSB +: MTAG_W] = a.mtag;
    w[LOCK_BIT]           = lock;
    return w;
  endfunction
endpackage

// File: rtl/buserr_lock.sv
module buserr_lock
  import buserr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       err_strobe,
  input  logic       reg_wr_en,
  input  logic [1:0] reg_sel,
  input  logic       wdata_lsb,
  output logic       lock_q,
  output logic       cap_fire
);
  logic unlock_wr;

  assign unlock_wr = reg_wr_en && (reg_sel == SEL_ATTR) && wdata_lsb;
  // a fresh error wins over a same-cycle unlock: it is recorded and relocks
  assign cap_fire  = err_strobe && (!lock_q || unlock_wr);

  always_ff @(posedge clk) begin
    if (rst)            lock_q <= 1'b0;
    else if (cap_fire)  lock_q <= 1'b1;
    else if (unlock_wr) lock_q <= 1'b0;
  end
endmodule

// File: rtl/buserr_store.sv
module buserr_store
  import buserr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              cap_fire,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [DATA_W-1:0] err_data,
  input  err_attr_t         err_attr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output err_attr_t         attr_q
);
  // captured fields carry no reset: they are meaningful only while locked
  always_ff @(posedge clk) begin
    if (cap_fire) begin
      addr_q <= err_addr;
      data_q <= err_data;
      attr_q <= err_attr;
    end
  end
endmodule

// File: rtl/buserr_regif.sv
module buserr_regif
  import buserr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] addr_word,
  input  logic [REG_W-1:0] dlo_word,
  input  logic [REG_W-1:0] dhi_word,
  input  logic [REG_W-1:0] attr_word,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] mux_word;

  always_comb begin
    unique case (reg_sel_e'(sel))
      SEL_ADDR: mux_word = addr_word;
      SEL_DLO:  mux_word = dlo_word;
      SEL_DHI:  mux_word = dhi_word;
      default:  mux_word = attr_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= mux_word;
  end
endmodule

// File: rtl/buserr_capture.sv
module buserr_capture
  import buserr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_strobe,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [DATA_W-1:0] err_data,
  input  logic [3:0]        err_opcode,
  input  logic [3:0]        err_tag,
  input  logic              err_read,
  input  logic              err_write,
  input  logic              err_super,
  input  logic              err_uis,
  input  logic [1:0]        err_ack,
  input  logic              err_single,
  input  logic [3:0]        err_mtag,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int HALF_W = DATA_W / 2;

  logic              lock_q;
  logic              cap_fire;
  err_attr_t         err_attr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  err_attr_t         attr_q;
  logic [REG_W-1:0]  addr_word;
  logic [REG_W-1:0]  attr_word;
  logic              wdata_unused;

  // only the lock bit of a write carries meaning
  assign wdata_unused = ^reg_wdata[REG_W-1:1];

  assign err_attr = '{opc: err_opcode, tag: err_tag, rd: err_read, wr: err_write,
                      sup: err_super, uis: err_uis, ack: err_ack,
                      single: err_single, mtag: err_mtag};

  buserr_lock u_lock (
    .clk        (clk),
    .rst        (rst),
    .err_strobe (err_strobe),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .wdata_lsb  (reg_wdata[0]),
    .lock_q     (lock_q),
    .cap_fire   (cap_fire)
  );

  buserr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .cap_fire (cap_fire),
    .err_addr (err_addr),
    .err_data (err_data),
    .err_attr (err_attr),
    .addr_q   (addr_q),
    .data_q   (data_q),
    .attr_q   (attr_q)
  );

  generate
    if (ADDR_W < REG_W) begin : g_addr_pad
      assign addr_word = {{(REG_W-ADDR_W){1'b0}}, addr_q};
    end else begin : g_addr_full
      assign addr_word = addr_q[REG_W-1:0];
    end
  endgenerate

  assign attr_word = pack_attr(attr_q, lock_q);

  buserr_regif u_regif (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (reg_rd_en),
    .sel       (reg_sel),
    .addr_word (addr_word),
    .dlo_word  (data_q[HALF_W-1:0]),
    .dhi_word  (data_q[DATA_W-1:HALF_W]),
    .attr_word (attr_word),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/buserr_capture_chk.sv
module buserr_capture_chk
  import buserr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              err_strobe,
  input logic [ADDR_W-1:0] err_addr,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [1:0]        reg_sel,
  input logic              wdata_lsb,
  input logic [31:0]       reg_rdata,
  input logic              lock_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] data_q,
  input err_attr_t         attr_q
);
  logic unlock_wr;
  assign unlock_wr = reg_wr_en && (reg_sel == 2'd3) && wdata_lsb;

  AST_RESET_UNLOCKED: assert property (@(posedge clk) rst |=> !lock_q); // R1

  AST_CAPTURE_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (err_strobe && !lock_q) |=> lock_q); // R2

  AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (rst)
    (err_strobe && !lock_q) |=> (addr_q == $past(err_addr))); // R2

  AST_LOCKED_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !unlock_wr) |=> (lock_q && $stable(addr_q) && $stable(data_q) && $stable(attr_q))); // R3

  AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (unlock_wr && !err_strobe) |=> !lock_q); // R4

  AST_ZERO_WRITE_NOP: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && (reg_sel == 2'd3) && !wdata_lsb && !err_strobe) |=> (lock_q == $past(lock_q))); // R5

  AST_SAME_CYCLE_RELOCK: assert property (@(posedge clk) disable iff (rst)
    (unlock_wr && err_strobe) |=> (lock_q && addr_q == $past(err_addr))); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_en |=> $stable(reg_rdata)); // R10
endmodule

bind buserr_capture buserr_capture_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .err_strobe (err_strobe),
  .err_addr   (err_addr),
  .reg_wr_en  (reg_wr_en),
  .reg_rd_en  (reg_rd_en),
  .reg_sel    (reg_sel),
  .wdata_lsb  (reg_wdata[0]),
  .reg_rdata  (reg_rdata),
  .lock_q     (lock_q),
  .addr_q     (addr_q),
  .data_q     (data_q),
  .attr_q     (attr_q)
);

// File: tb/tb_buserr_capture.sv
module tb_buserr_capture;
  localparam int AW = 24;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          err_strobe = 1'b0;
  logic [AW-1:0] err_addr = '0;
  logic [DW-1:0] err_data = '0;
  logic [3:0]    err_opcode = '0, err_tag = '0, err_mtag = '0;
  logic          err_read = 1'b0, err_write = 1'b0, err_super = 1'b0, err_uis = 1'b0, err_single = 1'b0;
  logic [1:0]    err_ack = '0;
  logic          reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  buserr_capture #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [3:0]    opc, tag, mtag;
    logic          rd, wr, sup, uis, single;
    logic [1:0]    ack;
  } ev_t;

  function automatic logic [31:0] want_attr(ev_t e, logic lk);
    return (32'(e.opc) << 28) | (32'(e.tag) << 22) | (32'(e.rd) << 21) |
           (32'(e.wr) << 20) | (32'(e.sup) << 19) | (32'(e.uis) << 18) |
           (32'(e.ack) << 16) | (32'(e.single) << 15) | (32'(e.mtag) << 4) | 32'(lk);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_ev(ev_t e);
    err_addr = e.addr; err_data = e.data; err_opcode = e.opc; err_tag = e.tag;
    err_mtag = e.mtag; err_read = e.rd; err_write = e.wr; err_super = e.sup;
    err_uis = e.uis; err_single = e.single; err_ack = e.ack; err_strobe = 1'b1;
  endtask

  task automatic raise_err(ev_t e);
    @(negedge clk); drive_ev(e);
    @(negedge clk); err_strobe = 1'b0;
  endtask

  task automatic reg_write(logic [1:0] s, logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] s, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1'b1; reg_sel = s;
    @(negedge clk); reg_rd_en = 1'b0; d = reg_rdata;
  endtask

  task automatic check_record(string req, ev_t e);
    logic [31:0] v;
    reg_read(2'd0, v); check({req, " addr"}, v, 32'(e.addr));
    reg_read(2'd1, v); check({req, " data lo"}, v, e.data[31:0]);
    reg_read(2'd2, v); check({req, " data hi"}, v, e.data[63:32]);
    reg_read(2'd3, v); check({req, " attr"}, v, want_attr(e, 1'b1));
  endtask

  ev_t ea, eb, ec;

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rdata after reset", reg_rdata, 32'h0);
    reg_read(2'd3, v);
    check("R1 attr low nibble", v & 32'hF, 32'h0);
  endtask

  task automatic t_first_capture();
    logic [31:0] v;
    raise_err(ea);
    check_record("R2/R7/R8 capture", ea);
    reg_read(2'd0, v);
    check("R9 address zero-extended", v & 32'hFF00_0000, 32'h0);
    reg_read(2'd3, v);
    check("R9 reserved attr bits", v & 32'h0C00_7F0E, 32'h0);
    check("R8 bus-lock bit single", (v >> 15) & 32'h1, 32'h1);
  endtask

  task automatic t_locked_ignore();
    raise_err(eb);
    check_record("R3 locked keeps first", ea);
  endtask

  task automatic t_sw_writes();
    reg_write(2'd3, 32'hFFFF_FFFE);
    reg_write(2'd0, 32'h00AB_CDEF);
    reg_write(2'd1, 32'h1111_1111);
    reg_write(2'd2, 32'h2222_2222);
    check_record("R5 writes without bit0 ignored", ea);
  endtask

  task automatic t_unlock_rearm();
    logic [31:0] v;
    reg_write(2'd3, 32'h0000_0001);
    reg_read(2'd3, v);
    check("R4 lock cleared", v & 32'h1, 32'h0);
    raise_err(eb);
    check_record("R4/R8 rearmed capture", eb);
    reg_read(2'd3, v);
    check("R8 bus-lock bit atomic", (v >> 15) & 32'h1, 32'h0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    drive_ev(ec);
    reg_wr_en = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h1;
    @(negedge clk);
    err_strobe = 1'b0; reg_wr_en = 1'b0;
    check_record("R6 same-cycle error captured", ec);
  endtask

  task automatic t_read_hold();
    logic [31:0] v;
    reg_read(2'd1, v);
    repeat (3) @(negedge clk);
    check("R10 rdata holds", reg_rdata, ec.data[31:0]);
    @(negedge clk); reg_rd_en = 1'b1; reg_sel = 2'd2;
    check("R10 not yet updated", reg_rdata, ec.data[31:0]);
    @(negedge clk); reg_rd_en = 1'b0;
    check("R10 updated after one edge", reg_rdata, ec.data[63:32]);
  endtask

  initial begin
    ea = '{addr: 24'hA5_1234, data: 64'h0123_4567_89AB_CDEF, opc: 4'hC, tag: 4'h5,
           mtag: 4'h9, rd: 1'b1, wr: 1'b0, sup: 1'b1, uis: 1'b0, single: 1'b1, ack: 2'b10};
    eb = '{addr: 24'h5A_FEDC, data: 64'hFEDC_BA98_7654_3210, opc: 4'h3, tag: 4'hA,
           mtag: 4'h6, rd: 1'b0, wr: 1'b1, sup: 1'b0, uis: 1'b1, single: 1'b0, ack: 2'b01};
    ec = '{addr: 24'hFF_0F0F, data: 64'hDEAD_BEEF_CAFE_F00D, opc: 4'hF, tag: 4'hF,
           mtag: 4'hF, rd: 1'b1, wr: 1'b1, sup: 1'b1, uis: 1'b1, single: 1'b1, ack: 2'b11};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_first_capture();
    t_locked_ignore();
    t_sw_writes();
    t_unlock_rearm();
    t_same_cycle();
    t_read_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule